// File: doc/BRIEF.md
# Instruction-Decoding Integer ALU

This block is a purely combinational integer unit that is driven directly by a 32-bit instruction word and two register operand values. It reads the primary opcode and, for register-format words, the function code. From these it picks an arithmetic, logic, compare or shift operation and produces the result in the same evaluation. For immediate-format words, the low 16 bits of the instruction form the second operand, extended by the rule that belongs to the instruction.

The caller fetches both register values and passes them in. The source register value is called `rs_val` and the second register value is called `rt_val`. The block reports which register index the result is meant for. Any encoding outside the supported set raises `illegal` and forces the result to zero. There are no clock, state or handshake signals. The result follows the inputs after the decode, extension and datapath logic settles.

Top module: `insn_alu`

## Requirements
- R1: When opcode insn[31:26]=0x00, funct insn[5:0]=0x20 gives rs_val+rt_val and funct 0x22 gives rs_val−rt_val. Both wrap modulo 2^32 and raise no flag.
- R2: When opcode is 0x00, funct 0x24 gives rs_val AND rt_val, 0x25 gives OR, and 0x26 gives XOR.
- R3: When opcode is 0x00, funct 0x2A gives 1 if rs_val < rt_val compared as two's-complement values. Funct 0x2B makes the same comparison unsigned. In both cases every other result bit is 0.
- R4: Opcode 0x08 gives rs_val plus insn[15:0] sign-extended to 32 bits, wrapping modulo 2^32.
- R5: Opcode 0x0C gives rs_val AND the zero-extended insn[15:0]. Opcode 0x0D gives rs_val OR the zero-extended insn[15:0].
- R6: When opcode is 0x00, funct 0x00 shifts rt_val left and funct 0x02 shifts it right, each by insn[10:6]. Vacated bits are filled with zeros, and rs_val has no effect on the result.
- R7: When opcode is 0x00, funct 0x04 shifts rt_val left and funct 0x06 shifts it right, by rs_val[4:0]. Vacated bits are filled with zeros. Neither insn[10:6] nor rs_val[31:5] has any effect.
- R8: Any opcode other than 0x00, 0x08, 0x0C or 0x0D raises `illegal`. So does opcode 0x00 with any funct outside the eleven values listed in R1, R2, R3, R6 and R7. While `illegal` is raised, result and dest_reg are both 0.
- R9: For a supported opcode-0x00 word, dest_reg is insn[15:11]. For a supported immediate word, it is insn[20:16].
- R10: For the opcode-0x00 add, subtract, logic and compare operations, insn[10:6] has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 32 | Instruction word |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| result | output | 32 | Operation result, zero when illegal |
| dest_reg | output | 5 | Index of the register the result is meant for |
| illegal | output | 1 | Unsupported encoding |

## Verification
Because the unit has no state, a wrong decode shows up at `result`, `dest_reg` or `illegal` in the same evaluation as the instruction that triggers it. The risk is that it may show only for particular operand values. An extension fault appears only when immediate bit 15 is set, and a fill fault appears only when rt_val has ones in the vacated positions. A shift-amount source swap appears only when insn[10:6] and rs_val[4:0] differ. For this reason, the directed vectors set those bits deliberately so that each fault changes a visible bit.

// File: rtl/insn_alu_pkg.sv
package insn_alu_pkg;

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_ANDI = 6'h0C;
  localparam logic [5:0] OPC_ORI  = 6'h0D;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SLLV = 6'h04;
  localparam logic [5:0] FN_SRLV = 6'h06;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_ADD,
    OP_SUB,
    OP_AND,
    OP_OR,
    OP_XOR,
    OP_LTS,
    OP_LTU,
    OP_SHL,
    OP_SHR
  } alu_op_e;

endpackage

// File: rtl/insn_alu_decode.sv
module insn_alu_decode
  import insn_alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [5:0]      opcode,
  input  logic [4:0]      rt_idx,
  input  logic [4:0]      rd_idx,
  input  logic [5:0]      funct,
  input  logic [15:0]     imm,
  output alu_op_e         op,
  output logic            b_is_imm,
  output logic [XLEN-1:0] imm_ext,
  output logic            amt_from_reg,
  output logic [4:0]      dest,
  output logic            illegal
);

  localparam int EXT_W = XLEN - 16;

  always_comb begin
    op           = OP_NONE;
    b_is_imm     = 1'b0;
    imm_ext      = '0;
    amt_from_reg = 1'b0;
    dest         = '0;
    illegal      = 1'b1;
    unique case (opcode)
      OPC_REG: begin
        illegal = 1'b0;
        dest    = rd_idx;
        unique case (funct)
          FN_ADD:  op = OP_ADD;
          FN_SUB:  op = OP_SUB;
          FN_AND:  op = OP_AND;
          FN_OR:   op = OP_OR;
          FN_XOR:  op = OP_XOR;
          FN_SLT:  op = OP_LTS;
          FN_SLTU: op = OP_LTU;
          FN_SLL:  op = OP_SHL;
          FN_SRL:  op = OP_SHR;
          FN_SLLV: begin op = OP_SHL; amt_from_reg = 1'b1; end
          FN_SRLV: begin op = OP_SHR; amt_from_reg = 1'b1; end
          default: begin illegal = 1'b1; dest = '0; end
        endcase
      end
      OPC_ADDI: begin
        illegal  = 1'b0;
        op       = OP_ADD;
        b_is_imm = 1'b1;
        imm_ext  = {{EXT_W{imm[15]}}, imm};
        dest     = rt_idx;
      end
      OPC_ANDI: begin
        illegal  = 1'b0;
        op       = OP_AND;
        b_is_imm = 1'b1;
        imm_ext  = {{EXT_W{1'b0}}, imm};
        dest     = rt_idx;
      end
      OPC_ORI: begin
        illegal  = 1'b0;
        op       = OP_OR;
        b_is_imm = 1'b1;
        imm_ext  = {{EXT_W{1'b0}}, imm};
        dest     = rt_idx;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown({opcode, funct})) begin
      // R8
      illegal_quiet_chk: assert (!illegal || (op == OP_NONE && dest == '0))
        else $error("illegal decode still selects an operation");
      // R4
      imm_only_nonreg_chk: assert (illegal || (b_is_imm == (opcode != OPC_REG)))
        else $error("immediate operand used on register format");
    end
  end

endmodule

// File: rtl/insn_alu_shifter.sv
module insn_alu_shifter #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]         din,
  input  logic [$clog2(XLEN)-1:0] amt,
  input  logic                    to_left,
  output logic [XLEN-1:0]         dout
);

  localparam int SHW = $clog2(XLEN);

  logic [XLEN-1:0] stage [0:SHW];

  assign stage[0] = din;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int DIST = 1 << s;
    always_comb begin
      if (!amt[s])      stage[s+1] = stage[s];
      else if (to_left) stage[s+1] = stage[s] << DIST;
      else              stage[s+1] = stage[s] >> DIST;
    end
  end

  assign dout = stage[SHW];

  always_comb begin
    if (!$isunknown({din, amt, to_left})) begin
      // R6
      zero_amt_chk: assert (amt != '0 || dout == din)
        else $error("zero shift altered data");
      // R7
      zero_fill_chk: assert (amt == '0 ||
          (to_left  && ((dout << (XLEN - int'(amt))) == '0)) ||
          (!to_left && ((dout >> (XLEN - int'(amt))) == '0)))
        else $error("vacated bits not zero");
    end
  end

endmodule

// File: rtl/insn_alu_arith.sv
module insn_alu_arith
  import insn_alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);

  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_LTS:  y = XLEN'($signed(a) < $signed(b));
      OP_LTU:  y = XLEN'(a < b);
      default: y = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({op, a, b})) begin
      // R3
      compare_bit0_chk: assert (!(op == OP_LTS || op == OP_LTU) || y[XLEN-1:1] == '0)
        else $error("compare result wider than one bit");
      // R1
      add_wrap_chk: assert (op != OP_ADD || (y - b) == a)
        else $error("sum inconsistent");
      // R1
      sub_wrap_chk: assert (op != OP_SUB || (y + b) == a)
        else $error("difference inconsistent");
    end
  end

endmodule

// File: rtl/insn_alu.sv
module insn_alu
  import insn_alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output logic [XLEN-1:0] result,
  output logic [4:0]      dest_reg,
  output logic            illegal
);

  localparam int SHW = $clog2(XLEN);

  alu_op_e         op;
  logic            b_is_imm;
  logic [XLEN-1:0] imm_ext;
  logic            amt_from_reg;
  logic [XLEN-1:0] opnd_b;
  logic [SHW-1:0]  sh_amt;
  logic [XLEN-1:0] sh_out;
  logic [XLEN-1:0] ar_out;
  logic            is_shift;
  logic            unused_rs_field;

  assign unused_rs_field = ^insn[25:21];

  insn_alu_decode #(.XLEN(XLEN)) dec_i (
    .opcode       (insn[31:26]),
    .rt_idx       (insn[20:16]),
    .rd_idx       (insn[15:11]),
    .funct        (insn[5:0]),
    .imm          (insn[15:0]),
    .op           (op),
    .b_is_imm     (b_is_imm),
    .imm_ext      (imm_ext),
    .amt_from_reg (amt_from_reg),
    .dest         (dest_reg),
    .illegal      (illegal)
  );

  assign opnd_b   = b_is_imm ? imm_ext : rt_val;
  assign sh_amt   = amt_from_reg ? rs_val[SHW-1:0] : insn[6 +: SHW];
  assign is_shift = (op == OP_SHL) || (op == OP_SHR);

  insn_alu_arith #(.XLEN(XLEN)) arith_i (
    .op (op),
    .a  (rs_val),
    .b  (opnd_b),
    .y  (ar_out)
  );

  insn_alu_shifter #(.XLEN(XLEN)) shift_i (
    .din     (rt_val),
    .amt     (sh_amt),
    .to_left (op == OP_SHL),
    .dout    (sh_out)
  );

  always_comb begin
    if (illegal)       result = '0;
    else if (is_shift) result = sh_out;
    else               result = ar_out;
  end

  always_comb begin
    if (!$isunknown({insn, rs_val, rt_val})) begin
      // R8
      illegal_zero_chk: assert (!illegal || result == '0)
        else $error("illegal word produced nonzero result");
      // R9
      reg_dest_chk: assert (illegal || insn[31:26] != 6'h00 || dest_reg == insn[15:11])
        else $error("register-format destination wrong");
      // R9
      imm_dest_chk: assert (illegal || insn[31:26] == 6'h00 || dest_reg == insn[20:16])
        else $error("immediate-format destination wrong");
    end
  end

endmodule

// File: tb/insn_alu_tb_top.sv
module insn_alu_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] insn = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [31:0] result;
  logic [4:0]  dest_reg;
  logic        illegal;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  insn_alu dut_i (
    .insn     (insn),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .result   (result),
    .dest_reg (dest_reg),
    .illegal  (illegal)
  );

  function automatic logic [31:0] rword(input logic [5:0] fn, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [4:0] rd,
                                        input logic [4:0] sh);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] iword(input logic [5:0] opc, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {opc, rs, rt, imm};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [31:0] w, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] exp_res,
                       input logic exp_ill, input logic [4:0] exp_dest);
    @(negedge clk);
    insn = w; rs_val = a; rt_val = b;
    #1;
    chk(tag, "result",   result,          exp_res);
    chk(tag, "illegal",  32'(illegal),    32'(exp_ill));
    chk(tag, "dest_reg", 32'(dest_reg),   32'(exp_dest));
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    #1;
    chk("R6", "idle result",  result,       32'h0);
    chk("R8", "idle illegal", 32'(illegal), 32'h0);
    chk("R9", "idle dest",    32'(dest_reg), 32'h0);
  endtask

  task automatic t_add_sub;
    apply("R1", rword(6'h20, 5'd1, 5'd2, 5'd5, 5'd0), 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 1'b0, 5'd5);
    apply("R1", rword(6'h20, 5'd1, 5'd2, 5'd6, 5'd0), 32'hFFFF_FFFF, 32'h2, 32'h0000_0001, 1'b0, 5'd6);
    apply("R1", rword(6'h22, 5'd1, 5'd2, 5'd7, 5'd0), 32'h0, 32'h1, 32'hFFFF_FFFF, 1'b0, 5'd7);
    apply("R10", rword(6'h20, 5'd1, 5'd2, 5'd8, 5'd19), 32'h10, 32'h5, 32'h15, 1'b0, 5'd8);
    apply("R10", rword(6'h2A, 5'd1, 5'd2, 5'd8, 5'd31), 32'h1, 32'h2, 32'h1, 1'b0, 5'd8);
  endtask

  task automatic t_logic;
    apply("R2", rword(6'h24, 5'd3, 5'd4, 5'd9, 5'd0), 32'hA5A5_F00F, 32'h0F0F_FFF0, 32'h0505_F000, 1'b0, 5'd9);
    apply("R2", rword(6'h25, 5'd3, 5'd4, 5'd10, 5'd0), 32'hA5A5_F00F, 32'h0F0F_FFF0, 32'hAFAF_FFFF, 1'b0, 5'd10);
    apply("R2", rword(6'h26, 5'd3, 5'd4, 5'd11, 5'd0), 32'hA5A5_F00F, 32'h0F0F_FFF0, 32'hAAAA_0FFF, 1'b0, 5'd11);
  endtask

  task automatic t_compare;
    apply("R3", rword(6'h2A, 5'd1, 5'd2, 5'd3, 5'd0), 32'hFFFF_FFFF, 32'h1, 32'h1, 1'b0, 5'd3);
    apply("R3", rword(6'h2B, 5'd1, 5'd2, 5'd3, 5'd0), 32'hFFFF_FFFF, 32'h1, 32'h0, 1'b0, 5'd3);
    apply("R3", rword(6'h2A, 5'd1, 5'd2, 5'd3, 5'd0), 32'h1, 32'hFFFF_FFFF, 32'h0, 1'b0, 5'd3);
    apply("R3", rword(6'h2B, 5'd1, 5'd2, 5'd3, 5'd0), 32'h1, 32'hFFFF_FFFF, 32'h1, 1'b0, 5'd3);
    apply("R3", rword(6'h2A, 5'd1, 5'd2, 5'd3, 5'd0), 32'h8000_0000, 32'h8000_0000, 32'h0, 1'b0, 5'd3);
  endtask

  task automatic t_imm;
    apply("R4", iword(6'h08, 5'd1, 5'd12, 16'hFFFF), 32'd10, 32'hDEAD_BEEF, 32'd9, 1'b0, 5'd12);
    apply("R4", iword(6'h08, 5'd1, 5'd13, 16'h7FFF), 32'd10, 32'h0, 32'h0000_8009, 1'b0, 5'd13);
    apply("R4", iword(6'h08, 5'd1, 5'd14, 16'h0001), 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0, 5'd14);
    apply("R5", iword(6'h0C, 5'd1, 5'd15, 16'h8001), 32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_8001, 1'b0, 5'd15);
    apply("R5", iword(6'h0D, 5'd1, 5'd16, 16'h8000), 32'h0, 32'hFFFF_FFFF, 32'h0000_8000, 1'b0, 5'd16);
    apply("R9", iword(6'h0D, 5'd31, 5'd0, 16'h00F0), 32'h0F00_0000, 32'h0, 32'h0F00_00F0, 1'b0, 5'd0);
  endtask

  task automatic t_fixed_shift;
    apply("R6", rword(6'h00, 5'd1, 5'd2, 5'd4, 5'd31), 32'hFFFF_FFFF, 32'h1, 32'h8000_0000, 1'b0, 5'd4);
    apply("R6", rword(6'h02, 5'd1, 5'd2, 5'd4, 5'd31), 32'h0000_0003, 32'h8000_0000, 32'h1, 1'b0, 5'd4);
    apply("R6", rword(6'h02, 5'd1, 5'd2, 5'd4, 5'd4), 32'h0000_0001, 32'hFFFF_FFFF, 32'h0FFF_FFFF, 1'b0, 5'd4);
    apply("R6", rword(6'h00, 5'd1, 5'd2, 5'd4, 5'd0), 32'h0000_001F, 32'hCAFE_0001, 32'hCAFE_0001, 1'b0, 5'd4);
  endtask

  task automatic t_var_shift;
    apply("R7", rword(6'h04, 5'd1, 5'd2, 5'd20, 5'd7), 32'hFFFF_FFE3, 32'h11, 32'h88, 1'b0, 5'd20);
    apply("R7", rword(6'h06, 5'd1, 5'd2, 5'd21, 5'd9), 32'h0000_0020, 32'h8000_00F0, 32'h8000_00F0, 1'b0, 5'd21);
    apply("R7", rword(6'h06, 5'd1, 5'd2, 5'd21, 5'd0), 32'h0000_001C, 32'hF000_0000, 32'h0000_000F, 1'b0, 5'd21);
  endtask

  task automatic t_illegal;
    apply("R8", iword(6'h23, 5'd1, 5'd2, 16'h0004), 32'h5, 32'h6, 32'h0, 1'b1, 5'd0);
    apply("R8", rword(6'h21, 5'd1, 5'd2, 5'd9, 5'd0), 32'h5, 32'h6, 32'h0, 1'b1, 5'd0);
    apply("R8", rword(6'h03, 5'd1, 5'd2, 5'd9, 5'd2), 32'h5, 32'h8000_0000, 32'h0, 1'b1, 5'd0);
    apply("R8", iword(6'h0E, 5'd1, 5'd2, 16'hFFFF), 32'h5, 32'h6, 32'h0, 1'b1, 5'd0);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_add_sub();
    t_logic();
    t_compare();
    t_imm();
    t_fixed_shift();
    t_var_shift();
    t_illegal();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule